// File: doc/BRIEF.md
# Bitslip Word Alignment Controller

This block sits beside a set of deserializer channels and finds the word boundary of each one. It drives a one-cycle bitslip request into a shifter it does not contain. Each request moves the channel's parallel word by one bit position. The block does not model the shifter or the deserializer.

It has two ways of working, and the choice is latched on each start. In search mode, every channel compares its received parallel word with a control character. On a mismatch it requests a slip, waits for the shifted data to settle, and compares again. It stops when the word matches, or it gives up once it has requested as many slips as the rollover limit allows. In fixed mode, every channel issues a preset number of slips and then reports itself aligned. This suits links where the clock-to-data relationship is known in advance.

A separate slip reset clears every channel at any time. Alignment begins only on a start pulse that arrives while that reset is released. Issuing start again re-runs the sequence, for example after the clocking has been re-locked. The channels work in parallel and independently of one another.

Top module: `bitslip_aligner`

## Requirements
- R1: After rst_n or slip_rst, on every channel bitslip, aligned and fail are low from the next clock edge onward, and the slip position count is cleared.
- R2: Without a start pulse, and for a start pulse that arrives while slip_rst is high, no channel issues a bitslip and no flag rises.
- R3: In search mode, a channel whose word differs from ctrl_char issues a single-cycle bitslip. It keeps doing so until the word equals ctrl_char, then raises aligned. The number of pulses equals the rotation still needed.
- R4: The first bitslip after start comes LAT+1 cycles after start is sampled. Every later bitslip on the same channel comes LAT+1 cycles after the previous one.
- R5: In search mode, a channel that has issued ROLL pulses and still sees no match at its next comparison raises fail. It then issues no more pulses. ROLL defaults to W, the deserialization factor.
- R6: Once aligned or fail is high, the flag holds and the channel issues no bitslip until the next slip_rst or start.
- R7: In fixed mode, each channel issues exactly slip_count pulses, with a count of zero giving none, and then raises aligned. ctrl_char and rx_data have no effect in this mode.
- R8: A start pulse from an aligned or failed state clears the flag and runs the alignment again.
- R9: Channels align independently. all_aligned is high exactly when every channel's aligned flag is high.
- R10: A slip_rst in the middle of a run stops further pulses from the next edge. The block stays quiet until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | parallel-word clock |
| rst_n | input | 1 | asynchronous active-low reset |
| slip_rst | input | 1 | synchronous clear of all channels; start is ignored while it is high |
| start | input | 1 | begins or restarts alignment |
| fixed_mode | input | 1 | 1 = issue a preset pulse count, 0 = search for ctrl_char; latched on start |
| ctrl_char | input | W | word that marks the boundary |
| slip_count | input | $clog2(ROLL+1) | number of pulses in fixed mode, latched on start |
| rx_data | input | NCH*W | parallel words, channel c in bits [c*W +: W] |
| bitslip | output | NCH | one-cycle slip requests, one bit per channel |
| aligned | output | NCH | per-channel aligned flag |
| fail | output | NCH | per-channel rollover failure flag |
| all_aligned | output | 1 | AND of all aligned flags |

## Verification
A wrong wait counter shows as bitslip pulses spaced other than LAT+1 cycles apart, and it is visible from the first pulse after start. A wrong slip counter shows as an aligned flag after the wrong number of pulses. It can also show as a fail flag that rises early or late, and this becomes visible within ROLL*(LAT+1)+LAT+1 cycles of start. A state that fails to clear or hold shows as a pulse while a flag is high, or as activity after slip_rst, and each case appears within one cycle.

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int NCH  = 2,
  parameter int W    = 8,
  parameter int ROLL = W,
  parameter int LAT  = 2,
  localparam int CW  = $clog2(ROLL + 1),
  localparam int LW  = (LAT > 0) ? $clog2(LAT + 1) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slip_rst,
  input  logic           start,
  input  logic           fixed_mode,
  input  logic [W-1:0]   ctrl_char,
  input  logic [CW-1:0]  slip_count,
  input  logic [NCH*W-1:0] rx_data,
  output logic [NCH-1:0] bitslip,
  output logic [NCH-1:0] aligned,
  output logic [NCH-1:0] fail,
  output logic           all_aligned
);

  typedef enum logic [1:0] {IDLE, RUN, DONE, BAD} st_t;

  st_t           st   [NCH];
  logic [LW-1:0] wcnt [NCH];
  logic [CW-1:0] n    [NCH];
  logic          fx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx      <= 1'b0;
      bitslip <= '0;
      for (int c = 0; c < NCH; c++) begin
        st[c]   <= IDLE;
        wcnt[c] <= '0;
        n[c]    <= '0;
      end
    end else begin
      if (start && !slip_rst) fx <= fixed_mode;
      for (int c = 0; c < NCH; c++) begin
        bitslip[c] <= 1'b0;
        if (slip_rst) begin
          st[c]   <= IDLE;
          wcnt[c] <= '0;
          n[c]    <= '0;
        end else if (start) begin
          st[c]   <= RUN;
          wcnt[c] <= LW'(LAT);
          n[c]    <= fixed_mode ? slip_count : '0;
        end else if (st[c] == RUN) begin
          if (wcnt[c] != '0) begin
            wcnt[c] <= wcnt[c] - 1'b1;
          end else if (fx) begin
            if (n[c] == '0) st[c] <= DONE;
            else begin
              bitslip[c] <= 1'b1;
              n[c]       <= n[c] - 1'b1;
              wcnt[c]    <= LW'(LAT);
            end
          end else if (rx_data[c*W +: W] == ctrl_char) begin
            st[c] <= DONE;
          end else if (n[c] == CW'(ROLL)) begin
            st[c] <= BAD;
          end else begin
            bitslip[c] <= 1'b1;
            n[c]       <= n[c] + 1'b1;
            wcnt[c]    <= LW'(LAT);
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    assign aligned[g] = (st[g] == DONE);
    assign fail[g]    = (st[g] == BAD);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      slip_rst |=> !bitslip[g] && !aligned[g] && !fail[g]);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bitslip[g] |=> !bitslip[g]);
    a_r6_aligned_holds: assert property (@(posedge clk) disable iff (!rst_n)
      aligned[g] && !slip_rst && !start |=> aligned[g] && !bitslip[g]);
    a_r5_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      fail[g] && !slip_rst && !start |=> fail[g] && !bitslip[g]);
  end

  assign all_aligned = &aligned;

endmodule

// File: tb/bitslip_aligner_test.sv
module bitslip_aligner_test;
  localparam int NCH = 2, W = 8, ROLL = 8, LAT = 2;
  localparam int CW = $clog2(ROLL + 1);
  localparam logic [W-1:0] CH = 8'h1D;

  logic clk = 0, rst_n = 0, slip_rst = 0, start = 0, fixed_mode = 0;
  logic [W-1:0] ctrl_char = CH;
  logic [CW-1:0] slip_count = '0;
  logic [NCH*W-1:0] rx_data;
  logic [NCH-1:0] bitslip, aligned, fail;
  logic all_aligned;

  bitslip_aligner #(.NCH(NCH), .W(W), .ROLL(ROLL), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .slip_rst(slip_rst), .start(start),
    .fixed_mode(fixed_mode), .ctrl_char(ctrl_char), .slip_count(slip_count),
    .rx_data(rx_data), .bitslip(bitslip), .aligned(aligned), .fail(fail),
    .all_aligned(all_aligned));

  always #4 clk = ~clk;

  int nchk = 0, nbad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int k);
    logic [2*W-1:0] d;
    d = {x, x} << (k % W);
    return d[2*W-1:W];
  endfunction

  // shifter model: each slip rotates the channel word by one position
  logic [W-1:0] base [NCH];
  int off [NCH];
  always @(posedge clk)
    for (int c = 0; c < NCH; c++) if (bitslip[c]) off[c] <= off[c] + 1;
  always_comb
    for (int c = 0; c < NCH; c++) rx_data[c*W +: W] = rotl(base[c], off[c]);

  // scoreboard: code = pulse count on aligned, 1000 + count on fail
  int exp_q [NCH][$];
  int cnt [NCH], since [NCH], tot [NCH];
  bit first [NCH], dprev [NCH];

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      since[c]++;
      if (start) begin since[c] = 0; first[c] = 1; cnt[c] = 0; end
      if (slip_rst) cnt[c] = 0;
      if (bitslip[c]) begin
        tot[c]++; cnt[c]++;
        check(since[c] == (first[c] ? LAT + 2 : LAT + 1), "R4 pulse spacing",
              since[c], first[c] ? LAT + 2 : LAT + 1);
        check(!dprev[c], "R6 pulse after flag", 1, 0);
        since[c] = 0; first[c] = 0;
      end
      if ((aligned[c] | fail[c]) && !dprev[c]) begin
        int got, want;
        got = fail[c] ? 1000 + cnt[c] : cnt[c];
        want = (exp_q[c].size() > 0) ? exp_q[c].pop_front() : -1;
        check(got == want, "R3/R5/R7 result code", got, want);
      end
      dprev[c] = aligned[c] | fail[c];
    end
  end

  task automatic go(input bit fm);
    @(posedge clk); #2 fixed_mode = fm; start = 1;
    @(posedge clk); #2 start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #2;
      if (&(aligned | fail)) break;
    end
    repeat (2) @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 20000);
    nbad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int t0, t1;
    for (int c = 0; c < NCH; c++) begin
      base[c] = CH; off[c] = 0; cnt[c] = 0; since[c] = 0; tot[c] = 0;
      first[c] = 0; dprev[c] = 0;
    end
    repeat (3) @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    check(bitslip == 0 && aligned == 0 && fail == 0, "R1 reset state",
          {bitslip, aligned, fail}, 0);

    // R2: start while slip_rst is held, then idle without start
    base[0] = 8'hFF; base[1] = 8'hFF;
    @(posedge clk); #2 slip_rst = 1; start = 1;
    @(posedge clk); #2 start = 0;
    repeat (4) @(posedge clk); #2 slip_rst = 0;
    repeat (20) @(posedge clk); #2;
    check(tot[0] + tot[1] == 0, "R2 no pulses", tot[0] + tot[1], 0);
    check(aligned == 0 && fail == 0, "R2 no flags", {aligned, fail}, 0);

    // R3/R9: search, channel 0 offset 3, channel 1 already aligned
    base[0] = rotl(CH, 3); base[1] = CH;
    exp_q[0].push_back(5); exp_q[1].push_back(0);
    go(0); wait_done();
    check(all_aligned == 1, "R9 all aligned", all_aligned, 1);
    t0 = tot[0];
    repeat (20) @(posedge clk); #2;
    check(tot[0] == t0 && aligned[0], "R6 hold without pulses", tot[0], t0);

    // R5/R8: restart with no match on ch0, ch1 offset 7
    off[0] = 0; off[1] = 0;
    base[0] = 8'hFF; base[1] = rotl(CH, 7);
    exp_q[0].push_back(1000 + ROLL); exp_q[1].push_back(1);
    go(0); wait_done();
    check(fail[0] && !aligned[0], "R5 fail flag", fail[0], 1);
    check(all_aligned == 0, "R9 not all aligned", all_aligned, 0);
    t0 = tot[0];
    repeat (30) @(posedge clk); #2;
    check(tot[0] == t0, "R5 quiet after fail", tot[0], t0);

    // R7: fixed mode ignores data and ctrl_char
    ctrl_char = 8'h00; slip_count = 3;
    exp_q[0].push_back(3); exp_q[1].push_back(3);
    go(1); wait_done();
    check(aligned == 2'b11, "R7 fixed aligned", aligned, 3);
    slip_count = 0;
    exp_q[0].push_back(0); exp_q[1].push_back(0);
    go(1); wait_done();
    check(aligned == 2'b11, "R7 zero count", aligned, 3);
    ctrl_char = CH;

    // R10: slip_rst in mid-search
    base[0] = 8'hFF; base[1] = 8'hFF;
    go(0);
    repeat (6) @(posedge clk); #2 slip_rst = 1;
    @(posedge clk); #2 slip_rst = 0;
    @(negedge clk);
    check(bitslip == 0 && aligned == 0 && fail == 0, "R10 cleared",
          {bitslip, aligned, fail}, 0);
    t0 = tot[0]; t1 = tot[1];
    repeat (30) @(posedge clk); #2;
    check(tot[0] == t0 && tot[1] == t1, "R10 stays quiet", tot[0] + tot[1], t0 + t1);

    // R3 again from the new position: offsets seen by the design
    off[0] = 0; off[1] = 0;
    base[0] = rotl(CH, 1); base[1] = rotl(CH, 6);
    exp_q[0].push_back(7); exp_q[1].push_back(2);
    go(0); wait_done();
    check(all_aligned == 1, "R9 all aligned again", all_aligned, 1);

    for (int c = 0; c < NCH; c++)
      check(exp_q[c].size() == 0, "R3 queue drained", exp_q[c].size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule